// File: doc/BRIEF.md
# Hash Uniformity Fitness Evaluator

This block grades how evenly an external hash circuit spreads a batch of random keys over its output indices. After a start request it clears an internal histogram, then produces pseudo-random 16-bit keys from a loadable shift-register generator. Each key goes to the hash circuit under test, and the hash result comes back as an 8-bit bin index. One hit is counted per returned index until the full batch of 4096 keys has been taken.

A sweep over all 256 bins then adds up the squared distance of every bin count from the ideal count of 16 hits. That ideal is 4096/256, whatever mapping is under test. The block reports the sum and the mean squared deviation, which is the sum divided by 256, and pulses a completion flag. A fitness score of 1/(1+variance) can be formed downstream. A uniformly random mapping lands near a variance of 16, and a better-spread mapping scores lower.

Top module: `hash_fitness_eval`

## Requirements
- R1: While reset is held, and after it is released with no start, busy_o, key_valid_o and done_o are 0 and sq_sum_o and variance_o are 0.
- R2: A start_i seen while idle begins a run. The generator loads seed_i, or 16'h0001 when seed_i is zero. The 256 bins are cleared one per cycle, for exactly 256 cycles with busy_o high and key_valid_o low, before the first key is shown.
- R3: During the feed phase key_o holds the generator state. After each accepted index it becomes {k[14:0], k[15]^k[14]^k[12]^k[3]}.
- R4: An index is accepted in a cycle where key_valid_o and idx_valid_i are both 1. While idx_valid_i is 0, key_o does not change. The feed phase ends after exactly 4096 accepted indices.
- R5: Bin counters never wrap. When all 4096 keys hit one bin, sq_sum_o is 16711680.
- R6: sq_sum_o equals the sum over all 256 bins of (hits − 16)². A perfectly even mapping gives 0.
- R7: variance_o equals sq_sum_o shifted right by 8 bits.
- R8: done_o is a one-cycle pulse in the first cycle after busy_o falls. sq_sum_o and variance_o change only in that cycle and hold until the next completion.
- R9: start_i is ignored while busy_o is high.
- R10: busy_o stays high for 512 + 4096 + (number of feed-phase cycles with idx_valid_i low) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run (used only while idle) |
| seed_i | input | 16 | Generator seed, loaded at start |
| key_o | output | 16 | Current key for the hash under test |
| key_valid_o | output | 1 | key_o is live and an index is awaited |
| idx_i | input | 8 | Bin index returned by the hash |
| idx_valid_i | input | 1 | idx_i is valid for the current key |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sq_sum_o | output | 32 | Sum of squared deviations from the ideal count |
| variance_o | output | 24 | Mean squared deviation (sum / 256) |

## Verification
A wrong generator step shows at key_o on the very next accepted key. The per-clock model comparison therefore catches it within one feed cycle. A bin that is not cleared, or a counter that is dropped or doubled, is invisible until the end of the sweep. It then shows as a wrong sq_sum_o in the done_o cycle. Runs with a constant mapping and a perfectly even mapping give exact known totals for that comparison. A phase counter off by one moves the busy_o fall and the done_o pulse, and the per-cycle check reports this in the cycle it happens.

// File: rtl/hfe_pkg.sv
package hfe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_FEED  = 2'd2,
    ST_SWEEP = 2'd3
  } hfe_state_e;

  // One step of a left-shifting Fibonacci generator up to 32 bits wide.
  function automatic logic [31:0] lfsr_step(input logic [31:0] s,
                                            input logic [31:0] taps,
                                            input int          width);
    logic        fb;
    logic [63:0] keep;
    fb   = ^(s & taps);
    keep = (64'd1 << width) - 64'd1;
    return 32'(({32'd0, s} << 1 | {63'd0, fb}) & keep);
  endfunction

  // Squared distance of a bin count from the ideal count.
  function automatic logic [31:0] dev_sq(input logic [31:0] hits,
                                         input logic [31:0] ideal);
    logic [31:0] d;
    d = (hits >= ideal) ? (hits - ideal) : (ideal - hits);
    return d * d;
  endfunction

endpackage

// File: rtl/hfe_key_lfsr.sv
module hfe_key_lfsr import hfe_pkg::*; #(
  parameter int             KEY_W    = 16,
  parameter logic [KEY_W-1:0] TAP_MASK = 16'hD008
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] seed_i,
  input  logic             step_i,
  output logic [KEY_W-1:0] key_o
);

  logic [KEY_W-1:0] state_q;
  logic [KEY_W-1:0] next_w;
  logic [KEY_W-1:0] seed_fix_w;

  assign next_w     = KEY_W'(lfsr_step(32'(state_q), 32'(TAP_MASK), KEY_W));
  assign seed_fix_w = (seed_i == '0) ? KEY_W'(1) : seed_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      state_q <= KEY_W'(1);
    else if (load_i)  state_q <= seed_fix_w;
    else if (step_i)  state_q <= next_w;
  end

  assign key_o = state_q;

endmodule

// File: rtl/hfe_hist.sv
module hfe_hist #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_addr_i,
  input  logic             inc_en_i,
  input  logic [IDX_W-1:0] inc_addr_i,
  input  logic [IDX_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             inc_carry_o
);

  localparam int BINS = 1 << IDX_W;

  logic [CNT_W-1:0] bin_q [BINS];
  logic [CNT_W-1:0] inc_cur_w;
  logic [CNT_W:0]   inc_sum_w;

  assign inc_cur_w   = bin_q[inc_addr_i];
  assign inc_sum_w   = {1'b0, inc_cur_w} + (CNT_W+1)'(1);
  assign inc_carry_o = inc_en_i & inc_sum_w[CNT_W];
  assign rd_data_o   = bin_q[rd_addr_i];

  always_ff @(posedge clk_i) begin
    for (int b = 0; b < BINS; b++) begin
      if (clr_en_i && clr_addr_i == IDX_W'(b))
        bin_q[b] <= '0;
      else if (inc_en_i && inc_addr_i == IDX_W'(b))
        bin_q[b] <= inc_sum_w[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/hfe_sweep_acc.sv
module hfe_sweep_acc import hfe_pkg::*; #(
  parameter int CNT_W = 13,
  parameter int SUM_W = 32,
  parameter int IDEAL = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             first_i,
  input  logic [CNT_W-1:0] bin_i,
  output logic [SUM_W-1:0] sum_next_o
);

  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] term_w;

  assign term_w     = SUM_W'(dev_sq(32'(bin_i), 32'(IDEAL)));
  assign sum_next_o = (first_i ? '0 : acc_q) + term_w;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum_next_o;
  end

endmodule

// File: rtl/hash_fitness_eval.sv
module hash_fitness_eval import hfe_pkg::*; #(
  parameter int               KEY_W    = 16,
  parameter int               IDX_W    = 8,
  parameter int               NUM_KEYS = 4096,
  parameter int               SUM_W    = 32,
  parameter logic [KEY_W-1:0] TAP_MASK = 16'hD008
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [KEY_W-1:0]     seed_i,
  output logic [KEY_W-1:0]     key_o,
  output logic                 key_valid_o,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 idx_valid_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [SUM_W-1:0]     sq_sum_o,
  output logic [SUM_W-IDX_W-1:0] variance_o
);

  localparam int BINS   = 1 << IDX_W;
  localparam int IDEAL  = NUM_KEYS / BINS;
  localparam int CNT_W  = $clog2(NUM_KEYS + 1);
  localparam int KCNT_W = $clog2(NUM_KEYS + 1);

  hfe_state_e        state_q;
  logic [IDX_W-1:0]  ptr_q;
  logic [KCNT_W-1:0] kcnt_q;
  logic              done_q;
  logic [SUM_W-1:0]  result_q;

  // Named internal events
  logic start_acc_w, key_take_w, ptr_last_w, feed_last_w;
  logic clear_en_w, sweep_en_w, sweep_first_w, sweep_last_w;
  logic inc_carry_w;
  logic [CNT_W-1:0] rd_bin_w;
  logic [SUM_W-1:0] sum_next_w;

  assign start_acc_w   = (state_q == ST_IDLE) && start_i;
  assign key_take_w    = (state_q == ST_FEED) && idx_valid_i;
  assign ptr_last_w    = (ptr_q == IDX_W'(BINS - 1));
  assign feed_last_w   = key_take_w && (kcnt_q == KCNT_W'(NUM_KEYS - 1));
  assign clear_en_w    = (state_q == ST_CLEAR);
  assign sweep_en_w    = (state_q == ST_SWEEP);
  assign sweep_first_w = sweep_en_w && (ptr_q == '0);
  assign sweep_last_w  = sweep_en_w && ptr_last_w;

  hfe_key_lfsr #(.KEY_W(KEY_W), .TAP_MASK(TAP_MASK)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_acc_w),
    .seed_i (seed_i),
    .step_i (key_take_w),
    .key_o  (key_o)
  );

  hfe_hist #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_hist (
    .clk_i       (clk_i),
    .clr_en_i    (clear_en_w),
    .clr_addr_i  (ptr_q),
    .inc_en_i    (key_take_w),
    .inc_addr_i  (idx_i),
    .rd_addr_i   (ptr_q),
    .rd_data_o   (rd_bin_w),
    .inc_carry_o (inc_carry_w)
  );

  hfe_sweep_acc #(.CNT_W(CNT_W), .SUM_W(SUM_W), .IDEAL(IDEAL)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (sweep_en_w),
    .first_i    (sweep_first_w),
    .bin_i      (rd_bin_w),
    .sum_next_o (sum_next_w)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      kcnt_q   <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_acc_w) begin
            state_q <= ST_CLEAR;
            ptr_q   <= '0;
            kcnt_q  <= '0;
          end
        end
        ST_CLEAR: begin
          ptr_q <= ptr_q + IDX_W'(1);
          if (ptr_last_w) state_q <= ST_FEED;
        end
        ST_FEED: begin
          if (key_take_w) kcnt_q <= kcnt_q + KCNT_W'(1);
          if (feed_last_w) begin
            state_q <= ST_SWEEP;
            ptr_q   <= '0;
          end
        end
        ST_SWEEP: begin
          ptr_q <= ptr_q + IDX_W'(1);
          if (sweep_last_w) begin
            state_q  <= ST_IDLE;
            result_q <= sum_next_w;
            done_q   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign key_valid_o = (state_q == ST_FEED);
  assign done_o      = done_q;
  assign sq_sum_o    = result_q;
  assign variance_o  = result_q[SUM_W-1:IDX_W];

endmodule

// File: rtl/hfe_checker.sv
module hfe_checker #(
  parameter int KEY_W    = 16,
  parameter int SUM_W    = 32,
  parameter int NUM_KEYS = 4096
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             key_valid_o,
  input logic             idx_valid_i,
  input logic [KEY_W-1:0] key_o,
  input logic             done_o,
  input logic [SUM_W-1:0] sq_sum_o,
  input logic             inc_carry
);

  localparam int ACW = $clog2(NUM_KEYS + 2);
  logic [ACW-1:0] seen_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                   seen_q <= '0;
    else if (!busy_o)              seen_q <= '0;
    else if (key_valid_o && idx_valid_i) seen_q <= seen_q + ACW'(1);
  end

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(sq_sum_o));

  assert_key_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_o && !idx_valid_i) |=> $stable(key_o));

  assert_accept_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q <= ACW'(NUM_KEYS));

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_carry);

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

endmodule

bind hash_fitness_eval hfe_checker #(.KEY_W(KEY_W), .SUM_W(SUM_W), .NUM_KEYS(NUM_KEYS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .key_valid_o (key_valid_o),
  .idx_valid_i (idx_valid_i),
  .key_o       (key_o),
  .done_o      (done_o),
  .sq_sum_o    (sq_sum_o),
  .inc_carry   (inc_carry_w)
);

// File: tb/sim_hash_fitness_eval.sv
module sim_hash_fitness_eval;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] seed_i = '0;
  logic [15:0] key_o;
  logic        key_valid_o;
  logic [7:0]  idx_i = '0;
  logic        idx_valid_i = 1'b0;
  logic        busy_o;
  logic        done_o;
  logic [31:0] sq_sum_o;
  logic [23:0] variance_o;

  always #2 clk_i = ~clk_i;

  hash_fitness_eval u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .seed_i(seed_i),
    .key_o(key_o), .key_valid_o(key_valid_o), .idx_i(idx_i),
    .idx_valid_i(idx_valid_i), .busy_o(busy_o), .done_o(done_o),
    .sq_sum_o(sq_sum_o), .variance_o(variance_o)
  );

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  int hmode   = 0;
  bit stall_on = 0;
  int neg_cnt = 0;
  int busy_cyc = 0;
  int stall_cyc = 0;

  // behavioural reference model
  int          m_state = 0;   // 0 idle, 1 clear, 2 feed, 3 sweep
  int          m_cnt = 0;
  int          m_key = 1;
  int          m_hist [256];
  longint      m_sum = 0;
  bit          m_done = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (!rst_ni) begin
      m_state = 0; m_sum = 0; m_done = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_state != 0) busy_cyc++;
      case (m_state)
        0: if (start_i) begin
             m_key = (seed_i == 0) ? 1 : int'(seed_i);
             m_state = 1; m_cnt = 0;
           end
        1: begin
             m_hist[m_cnt] = 0; m_cnt++;
             if (m_cnt == 256) begin m_state = 2; m_cnt = 0; end
           end
        2: begin
             if (!idx_valid_i) stall_cyc++;
             else begin
               int fb;
               m_hist[idx_i]++;
               fb = ((m_key >> 15) ^ (m_key >> 14) ^ (m_key >> 12) ^ (m_key >> 3)) & 1;
               m_key = ((m_key * 2) + fb) % 65536;
               m_cnt++;
               if (m_cnt == 4096) begin m_state = 3; m_cnt = 0; end
             end
           end
        default: begin
             m_cnt++;
             if (m_cnt == 256) begin
               m_sum = 0;
               for (int b = 0; b < 256; b++)
                 m_sum += longint'(m_hist[b] - 16) * longint'(m_hist[b] - 16);
               m_done = 1; m_state = 0;
             end
           end
      endcase
    end
  end

  // per-clock comparison, then drive the hash response
  always @(negedge clk_i) begin
    neg_cnt++;
    if (!rst_ni) begin
      chk("R1 busy", busy_o, 0);
      chk("R1 done", done_o, 0);
      chk("R1 sum", sq_sum_o, 0);
      chk("R1 key_valid", key_valid_o, 0);
    end else begin
      chk("R10 busy phase", busy_o, m_state != 0);
      chk("R2 key_valid phase", key_valid_o, m_state == 2);
      if (m_state == 2) chk("R3 key sequence", key_o, m_key);
      chk("R8 done pulse", done_o, m_done);
      chk("R6 sum", sq_sum_o, m_sum);
      chk("R7 variance", variance_o, m_sum >> 8);
    end
    case (hmode)
      0: idx_i = key_o[15:8] ^ key_o[7:0];
      1: idx_i = 8'h5A;
      2: idx_i = 8'(m_cnt);
      default: idx_i = key_o[7:0];
    endcase
    idx_valid_i = stall_on ? ((neg_cnt % 5) != 2) : 1'b1;
  end

  always @(posedge clk_i) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic run(input logic [15:0] seed, input int mode, input bit stall, input bit mid_start);
    int b_neg;
    hmode = mode; stall_on = stall;
    @(negedge clk_i);
    busy_cyc = 0; stall_cyc = 0;
    seed_i = seed; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    b_neg = 0;
    while (!key_valid_o) begin b_neg++; @(negedge clk_i); end
    // R2: 256 clearing cycles (first counted above was the start cycle's negedge)
    chk("R2 clear length", b_neg, 256);
    chk("R2 first key", key_o, (seed == 0) ? 1 : seed);
    if (mid_start) begin
      repeat (300) @(negedge clk_i);
      seed_i = 16'h0F0F; start_i = 1'b1;   // R9: must be ignored
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk_i);
    chk("R10 busy length", busy_cyc, 512 + 4096 + stall_cyc);
    chk("R7 variance at done", variance_o, sq_sum_o >> 8);
    if (mode == 1) chk("R5 one-bin total", sq_sum_o, 16711680);
    if (mode == 2) chk("R6 even mapping total", sq_sum_o, 0);
    @(negedge clk_i);
    chk("R8 result hold", sq_sum_o, m_sum);
    chk("R8 done dropped", done_o, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 idle after reset", busy_o, 0);
    run(16'hACE1, 0, 0, 0);
    run(16'h0000, 1, 1, 0);
    run(16'h1234, 2, 0, 1);
    run(16'hBEEF, 3, 1, 0);
    run(16'h0001, 0, 1, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule